// File: doc/BRIEF.md
# Sampled PI Current Regulator with Duty-Tick Output

This block closes the inner current loop of one DC-DC converter leg. Each control step it takes one word from each of seven valid/ready streams. Three streams carry raw signed ADC codes: inductor current, input voltage and output voltage. Four carry parameters: current reference, proportional gain, integral gain and sampling period in nanoseconds. From these it forms a proportional-plus-integral correction. It adds the output voltage as feedforward and divides by the input voltage to get a duty ratio. The ratio is clamped to the range 0 to 1 and scaled by a static PWM period into an unsigned compare value for a modulator. All arithmetic is fixed point.

Every stream's tready is the same signal, raised only while the block is idle and all seven tvalid are high. A producer that presents its word early is held, and keeps its data stable, until the other six producers are also ready. Each accepted step yields exactly one result. The result is marked by a one-cycle strobe and comes with a saturation flag. The integrator keeps its state from step to step. It is frozen in any step whose result saturates, so that it does not wind up.

Top module: `pi_current_ctl`

## Requirements
- R1: All seven tready outputs are one shared signal. It is high only in a cycle where the block is idle and all seven tvalid are high. One word is taken from every stream per step, and tready is never high in two consecutive cycles.
- R2: The current error is e = reference − measured current, in current ADC codes, with both as signed 16-bit values. The proportional term is floor(Kp·e·6540 / 2^16), with Kp signed Q16.16. The factor 6540/2^16 is the ratio of the current and voltage sensor gains, so the term is in voltage codes with 16 fraction bits.
- R3: The per-step integral gain is G = floor(Ki·Ts·70369 / 2^46), with Ki signed Q16.16 and Ts an unsigned 32-bit count of nanoseconds; 70369/2^46 approximates 1e-9. The increment is floor(G·e·6540 / 2^16). The output uses the accumulator value held before this step, and the increment is added afterwards (forward Euler).
- R4: Let N = Vout·2^16 + P + A. When 0 < N < Vin·2^16, the duty is the unsigned Q1.15 value floor(N / (2·Vin)) and the saturation flag is 0. When N equals Vin·2^16 exactly, the duty is 32768 (1.0) and the flag is 0.
- R5: When N > Vin·2^16, the duty is 32768 (1.0) and the saturation flag is 1.
- R6: When N ≤ 0 and Vin > 0, the duty is 0 and the saturation flag is 1.
- R7: When Vin ≤ 0, the duty is 0 and the saturation flag is 1, whatever N is.
- R8: In a step whose saturation flag is 1, the accumulator keeps its previous value.
- R9: The tick output is floor(duty·period / 2^15), an unsigned 16-bit value, so it never exceeds the period input.
- R10: ticks_vld_o is high for exactly one cycle per accepted step. ticks_o and sat_o are valid in that cycle and hold until the next strobe.
- R11: Active-low reset clears the accumulator, ticks_o, sat_o and ticks_vld_o. After reset, the first steps behave as if no integration had ever taken place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_icur_tdata | input | 16 | Inductor current ADC code, signed |
| s_icur_tvalid | input | 1 | Current sample valid |
| s_icur_tready | output | 1 | Current sample taken |
| s_vin_tdata | input | 16 | Input voltage ADC code, signed |
| s_vin_tvalid | input | 1 | Input voltage valid |
| s_vin_tready | output | 1 | Input voltage taken |
| s_vout_tdata | input | 16 | Output voltage ADC code, signed |
| s_vout_tvalid | input | 1 | Output voltage valid |
| s_vout_tready | output | 1 | Output voltage taken |
| s_iref_tdata | input | 16 | Current reference in current codes, signed |
| s_iref_tvalid | input | 1 | Reference valid |
| s_iref_tready | output | 1 | Reference taken |
| s_kp_tdata | input | 32 | Proportional gain, signed Q16.16 |
| s_kp_tvalid | input | 1 | Kp valid |
| s_kp_tready | output | 1 | Kp taken |
| s_ki_tdata | input | 32 | Integral gain, signed Q16.16 per second |
| s_ki_tvalid | input | 1 | Ki valid |
| s_ki_tready | output | 1 | Ki taken |
| s_tsns_tdata | input | 32 | Sampling period in ns, unsigned |
| s_tsns_tvalid | input | 1 | Period valid |
| s_tsns_tready | output | 1 | Period taken |
| period_i | input | 16 | PWM period in ticks, static |
| ticks_o | output | 16 | Compare value for the modulator |
| ticks_vld_o | output | 1 | One-cycle strobe marking a new ticks_o |
| sat_o | output | 1 | Result of the last step was clamped |

## Verification
The accumulator is the only state that outlives a step. A wrong increment, a wrong sign or a missed freeze shows at the ports only in the steps that follow. It appears as a tick value that drifts away from the feedforward-only result by an amount that grows with each later step. The bench therefore runs long sequences over a grid of voltages, errors, gains and periods against an arithmetic model, and compares every step. Divider and clamp faults show in the same step's ticks_o and sat_o, within the fixed latency of about twenty cycles after the handshake.

// File: rtl/pi_ctl_pkg.sv
package pi_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAIN,
    ST_CLAMP,
    ST_DIV,
    ST_OUT
  } ctl_state_t;
endpackage

// File: rtl/pi_gain_stage.sv
// Two register stages: error and per-step integral gain, then the
// proportional term and the integrator increment in voltage codes.
module pi_gain_stage #(
  parameter int ADC_W = 16,
  parameter int PAR_W = 32,
  parameter int ACC_W = 48,
  parameter int FRAC  = 16,
  parameter int C2V   = 6540,
  parameter int NS_K  = 70369,
  parameter int NS_SH = 46
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic signed [ADC_W-1:0] iref,
  input  logic signed [ADC_W-1:0] icur,
  input  logic signed [PAR_W-1:0] kp,
  input  logic signed [PAR_W-1:0] ki,
  input  logic        [PAR_W-1:0] ts,
  output logic signed [ACC_W-1:0] p_term,
  output logic signed [ACC_W-1:0] i_inc,
  output logic                    done
);
  localparam int PW = 3 * PAR_W;
  localparam int EW = ADC_W + 1;
  localparam logic signed [PW-1:0] C2VX = PW'(C2V);
  localparam logic signed [PW-1:0] NSKX = PW'(NS_K);

  logic signed [EW-1:0]    err_d, err_q;
  logic signed [ACC_W-1:0] kits_d, kits_q;
  logic signed [PAR_W-1:0] kp_q;
  logic                    a_vld;

  logic signed [PW-1:0] ki_x, ts_x, kits_full, kits_sh;
  logic signed [PW-1:0] err_x, kp_x, kits_x;
  logic signed [PW-1:0] p_full, p_sh, inc_full, inc_sh;

  always_comb begin
    err_d     = {iref[ADC_W-1], iref} - {icur[ADC_W-1], icur};
    ki_x      = {{(PW-PAR_W){ki[PAR_W-1]}}, ki};
    ts_x      = {{(PW-PAR_W){1'b0}}, ts};
    kits_full = ki_x * ts_x * NSKX;
    kits_sh   = kits_full >>> NS_SH;
    kits_d    = kits_sh[ACC_W-1:0];

    err_x    = {{(PW-EW){err_q[EW-1]}}, err_q};
    kp_x     = {{(PW-PAR_W){kp_q[PAR_W-1]}}, kp_q};
    kits_x   = {{(PW-ACC_W){kits_q[ACC_W-1]}}, kits_q};
    p_full   = kp_x * err_x * C2VX;
    p_sh     = p_full >>> FRAC;
    inc_full = kits_x * err_x * C2VX;
    inc_sh   = inc_full >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      kits_q <= '0;
      kp_q   <= '0;
      p_term <= '0;
      i_inc  <= '0;
      a_vld  <= 1'b0;
      done   <= 1'b0;
    end else begin
      a_vld <= go;
      done  <= a_vld;
      if (go) begin
        err_q  <= err_d;
        kits_q <= kits_d;
        kp_q   <= kp;
      end
      if (a_vld) begin
        p_term <= p_sh[ACC_W-1:0];
        i_inc  <= inc_sh[ACC_W-1:0];
      end
    end
  end

  AST_GAIN_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
endmodule

// File: rtl/pi_duty_clamp.sv
// Feedforward sum, range decisions, and operands for the divider.
module pi_duty_clamp #(
  parameter int ADC_W = 16,
  parameter int PI_W  = 49,
  parameter int FRAC  = 16
) (
  input  logic signed [ADC_W-1:0]       vout,
  input  logic signed [ADC_W-1:0]       vin,
  input  logic signed [PI_W-1:0]        pi_sum,
  output logic                          need_div,
  output logic        [ADC_W-1:0]       duty_fix,
  output logic                          sat,
  output logic        [ADC_W+FRAC-1:0]  dividend,
  output logic        [ADC_W:0]         divisor
);
  localparam int NW = PI_W + 1;
  localparam int QW = ADC_W - 1;
  localparam logic [ADC_W-1:0] ONE_Q = {1'b1, {QW{1'b0}}};

  logic signed [NW-1:0] num, full;

  always_comb begin
    num  = {{(NW-ADC_W-FRAC){vout[ADC_W-1]}}, vout, {FRAC{1'b0}}}
         + {pi_sum[PI_W-1], pi_sum};
    full = {{(NW-ADC_W-FRAC){vin[ADC_W-1]}}, vin, {FRAC{1'b0}}};
    need_div = 1'b0;
    duty_fix = '0;
    sat      = 1'b0;
    dividend = num[ADC_W+FRAC-1:0];
    divisor  = {vin, 1'b0};
    if (vin[ADC_W-1] || vin == '0) begin
      sat = 1'b1;
    end else if (num[NW-1] || num == '0) begin
      sat = 1'b1;
    end else if (num > full) begin
      sat      = 1'b1;
      duty_fix = ONE_Q;
    end else if (num == full) begin
      duty_fix = ONE_Q;
    end else begin
      need_div = 1'b1;
    end
  end
endmodule

// File: rtl/pi_iter_div.sv
// Restoring divider, one quotient bit per cycle, most significant first.
module pi_iter_div #(
  parameter int DW = 32,
  parameter int VW = 17,
  parameter int QW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quot
);
  localparam int CW = $clog2(QW + 1);

  logic [DW-1:0] rem, dsh;
  logic [CW-1:0] cnt;
  logic          fits;

  assign fits = (rem >= dsh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      dsh  <= '0;
      cnt  <= '0;
      quot <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem  <= dividend;
        dsh  <= {{(DW-VW){1'b0}}, divisor} << (QW - 1);
        quot <= '0;
        cnt  <= CW'(QW);
        busy <= 1'b1;
      end else if (busy) begin
        if (fits) rem <= rem - dsh;
        quot <= {quot[QW-2:0], fits};
        dsh  <= dsh >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R4
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
endmodule

// File: rtl/pi_current_ctl.sv
module pi_current_ctl
  import pi_ctl_pkg::*;
#(
  parameter int ADC_W  = 16,
  parameter int PAR_W  = 32,
  parameter int ACC_W  = 48,
  parameter int TICK_W = 16,
  parameter int C2V    = 6540,
  parameter int NS_K   = 70369,
  parameter int NS_SH  = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADC_W-1:0]  s_icur_tdata,
  input  logic              s_icur_tvalid,
  output logic              s_icur_tready,
  input  logic [ADC_W-1:0]  s_vin_tdata,
  input  logic              s_vin_tvalid,
  output logic              s_vin_tready,
  input  logic [ADC_W-1:0]  s_vout_tdata,
  input  logic              s_vout_tvalid,
  output logic              s_vout_tready,
  input  logic [ADC_W-1:0]  s_iref_tdata,
  input  logic              s_iref_tvalid,
  output logic              s_iref_tready,
  input  logic [PAR_W-1:0]  s_kp_tdata,
  input  logic              s_kp_tvalid,
  output logic              s_kp_tready,
  input  logic [PAR_W-1:0]  s_ki_tdata,
  input  logic              s_ki_tvalid,
  output logic              s_ki_tready,
  input  logic [PAR_W-1:0]  s_tsns_tdata,
  input  logic              s_tsns_tvalid,
  output logic              s_tsns_tready,
  input  logic [TICK_W-1:0] period_i,
  output logic [TICK_W-1:0] ticks_o,
  output logic              ticks_vld_o,
  output logic              sat_o
);
  localparam int FRAC = 16;
  localparam int PI_W = ACC_W + 1;
  localparam int QW   = ADC_W - 1;
  localparam int DW   = ADC_W + FRAC;
  localparam int VW   = ADC_W + 1;
  localparam int PRW  = ADC_W + TICK_W;

  ctl_state_t state;

  logic                    all_valid, take;
  logic signed [ADC_W-1:0] vin_q, vout_q;
  logic signed [ACC_W-1:0] acc, p_term, i_inc;
  logic signed [PI_W-1:0]  pi_sum;
  logic                    gain_done;
  logic                    cl_need_div, cl_sat;
  logic [ADC_W-1:0]        cl_duty, duty_q;
  logic [DW-1:0]           cl_dividend, num_q;
  logic [VW-1:0]           cl_divisor, den_q;
  logic                    sat_q;
  logic                    div_start, div_busy, div_done;
  logic [QW-1:0]           div_quot;
  logic [PRW-1:0]          tick_prod;

  assign all_valid = s_icur_tvalid & s_vin_tvalid & s_vout_tvalid & s_iref_tvalid
                   & s_kp_tvalid & s_ki_tvalid & s_tsns_tvalid;
  assign take = (state == ST_IDLE) && all_valid;

  assign s_icur_tready = take;
  assign s_vin_tready  = take;
  assign s_vout_tready = take;
  assign s_iref_tready = take;
  assign s_kp_tready   = take;
  assign s_ki_tready   = take;
  assign s_tsns_tready = take;

  pi_gain_stage #(
    .ADC_W(ADC_W), .PAR_W(PAR_W), .ACC_W(ACC_W), .FRAC(FRAC),
    .C2V(C2V), .NS_K(NS_K), .NS_SH(NS_SH)
  ) i_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (take),
    .iref   (s_iref_tdata),
    .icur   (s_icur_tdata),
    .kp     (s_kp_tdata),
    .ki     (s_ki_tdata),
    .ts     (s_tsns_tdata),
    .p_term (p_term),
    .i_inc  (i_inc),
    .done   (gain_done)
  );

  assign pi_sum = {p_term[ACC_W-1], p_term} + {acc[ACC_W-1], acc};

  pi_duty_clamp #(.ADC_W(ADC_W), .PI_W(PI_W), .FRAC(FRAC)) i_clamp (
    .vout     (vout_q),
    .vin      (vin_q),
    .pi_sum   (pi_sum),
    .need_div (cl_need_div),
    .duty_fix (cl_duty),
    .sat      (cl_sat),
    .dividend (cl_dividend),
    .divisor  (cl_divisor)
  );

  assign div_start = (state == ST_CLAMP) && cl_need_div;

  pi_iter_div #(.DW(DW), .VW(VW), .QW(QW)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (cl_dividend),
    .divisor  (cl_divisor),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot)
  );

  assign tick_prod = {{TICK_W{1'b0}}, duty_q} * {{ADC_W{1'b0}}, period_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      acc         <= '0;
      vin_q       <= '0;
      vout_q      <= '0;
      duty_q      <= '0;
      sat_q       <= 1'b0;
      num_q       <= '0;
      den_q       <= '0;
      ticks_o     <= '0;
      ticks_vld_o <= 1'b0;
      sat_o       <= 1'b0;
    end else begin
      ticks_vld_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            vin_q  <= s_vin_tdata;
            vout_q <= s_vout_tdata;
            state  <= ST_GAIN;
          end
        end
        ST_GAIN: begin
          if (gain_done) state <= ST_CLAMP;
        end
        ST_CLAMP: begin
          sat_q  <= cl_sat;
          duty_q <= cl_duty;
          num_q  <= cl_dividend;
          den_q  <= cl_divisor;
          state  <= cl_need_div ? ST_DIV : ST_OUT;
        end
        ST_DIV: begin
          if (div_done) begin
            duty_q <= {1'b0, div_quot};
            state  <= ST_OUT;
          end
        end
        ST_OUT: begin
          ticks_o     <= tick_prod[QW+TICK_W-1:QW];
          ticks_vld_o <= 1'b1;
          sat_o       <= sat_q;
          if (!sat_q) acc <= acc + i_inc;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TAKE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    s_vin_tready |=> !s_kp_tready); // R1
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_vld_o |=> !ticks_vld_o); // R10
  AST_TICKS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_vld_o |-> ticks_o <= period_i); // R9
  AST_SAT_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (ticks_vld_o && sat_o) |-> (ticks_o == '0 || ticks_o == period_i)); // R5
  AST_DIV_BRACKET: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (({{(64-QW){1'b0}}, div_quot} * {{(64-VW){1'b0}}, den_q}
                   <= {{(64-DW){1'b0}}, num_q}) &&
                  ({{(64-DW){1'b0}}, num_q} <
                   ({{(64-QW){1'b0}}, div_quot} + 64'd1) * {{(64-VW){1'b0}}, den_q}))); // R4
endmodule

// File: tb/test_pi_current_ctl.sv
module test_pi_current_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] icur_d, vin_d, vout_d, iref_d;
  logic [31:0] kp_d, ki_d, ts_d;
  logic icur_v, vin_v, vout_v, iref_v, kp_v, ki_v, ts_v;
  logic icur_r, vin_r, vout_r, iref_r, kp_r, ki_r, ts_r;
  logic [15:0] period;
  logic [15:0] ticks;
  logic ticks_vld, sat;

  int checks = 0;
  int errors = 0;
  logic signed [127:0] m_acc = '0;

  pi_current_ctl i_pi_current_ctl (
    .clk(clk), .rst_n(rst_n),
    .s_icur_tdata(icur_d), .s_icur_tvalid(icur_v), .s_icur_tready(icur_r),
    .s_vin_tdata(vin_d),   .s_vin_tvalid(vin_v),   .s_vin_tready(vin_r),
    .s_vout_tdata(vout_d), .s_vout_tvalid(vout_v), .s_vout_tready(vout_r),
    .s_iref_tdata(iref_d), .s_iref_tvalid(iref_v), .s_iref_tready(iref_r),
    .s_kp_tdata(kp_d),     .s_kp_tvalid(kp_v),     .s_kp_tready(kp_r),
    .s_ki_tdata(ki_d),     .s_ki_tvalid(ki_v),     .s_ki_tready(ki_r),
    .s_tsns_tdata(ts_d),   .s_tsns_tvalid(ts_v),   .s_tsns_tready(ts_r),
    .period_i(period), .ticks_o(ticks), .ticks_vld_o(ticks_vld), .sat_o(sat)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic any_ready();
    return icur_r | vin_r | vout_r | iref_r | kp_r | ki_r | ts_r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {icur_v, vin_v, vout_v, iref_v, kp_v, ki_v, ts_v} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = '0;
  endtask

  // One control step: model, drive, wait, compare.
  task automatic run_step(input int iref, input int kp, input int ki, input longint ts,
                          input int icur, input int vin, input int vout, input int per,
                          input string hint);
    logic signed [127:0] e, kits, p, inc, num, full, duty, exp_t;
    bit exp_sat;
    string tag;
    int wait_n;
    e    = 128'(iref) - 128'(icur);
    kits = (128'(ki) * 128'(ts) * 128'(70369)) >>> 46;
    p    = (128'(kp) * e * 128'(6540)) >>> 16;
    inc  = (kits * e * 128'(6540)) >>> 16;
    num  = 128'(vout) * 128'(65536) + p + m_acc;
    full = 128'(vin) * 128'(65536);
    if (vin <= 0) begin duty = 0; exp_sat = 1; tag = "R7"; end
    else if (num <= 0) begin duty = 0; exp_sat = 1; tag = "R6"; end
    else if (num > full) begin duty = 32768; exp_sat = 1; tag = "R5"; end
    else begin duty = num / (128'(2) * 128'(vin)); exp_sat = 0; tag = "R4"; end
    if (hint != "") tag = hint;
    exp_t = (duty * 128'(per)) >>> 15;
    if (!exp_sat) m_acc = m_acc + inc;

    @(negedge clk);
    period = 16'(per);
    icur_d = 16'(icur); vin_d = 16'(vin); vout_d = 16'(vout); iref_d = 16'(iref);
    kp_d = 32'(kp); ki_d = 32'(ki); ts_d = 32'(ts);
    {icur_v, vin_v, vout_v, iref_v, kp_v, ki_v, ts_v} = '1;
    #1;
    while (!(icur_r & vin_r & vout_r & iref_r & kp_r & ki_r & ts_r)) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    {icur_v, vin_v, vout_v, iref_v, kp_v, ki_v, ts_v} = '0;
    wait_n = 0;
    @(negedge clk);
    while (!ticks_vld && wait_n < 100) begin
      @(negedge clk); wait_n++;
    end
    chk(ticks_vld, "R10", longint'(ticks_vld), 1);
    chk(ticks == 16'(exp_t), tag, longint'(ticks), longint'(exp_t));
    chk(sat == exp_sat, tag, longint'(sat), longint'(exp_sat));
    @(negedge clk);
    chk(!ticks_vld, "R10", longint'(ticks_vld), 0);
    chk(ticks == 16'(exp_t), "R10", longint'(ticks), longint'(exp_t));
  endtask

  function automatic int vin_of(int i);
    case (i) 0: return -100; 1: return 0; 2: return 3000; 3: return 12000; default: return 32767; endcase
  endfunction
  function automatic int vout_of(int i);
    case (i) 0: return 0; 1: return 1500; 2: return 6000; default: return 20000; endcase
  endfunction
  function automatic int per_of(int i);
    case (i) 0: return 1000; 1: return 4095; default: return 65535; endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    period = 16'd1000;
    {icur_d, vin_d, vout_d, iref_d} = '0;
    {kp_d, ki_d, ts_d} = '0;
    do_reset();
    // R11: reset state at the ports
    @(negedge clk);
    chk(ticks == 0, "R11", longint'(ticks), 0);
    chk(!ticks_vld && !sat, "R11", longint'({ticks_vld, sat}), 0);

    // R1: six of seven streams valid -> nothing taken, nothing produced
    @(negedge clk);
    {icur_v, vin_v, vout_v, iref_v, kp_v, ki_v} = '1; ts_v = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(!any_ready() && !ticks_vld, "R1", longint'({any_ready(), ticks_vld}), 0);
      @(negedge clk);
    end
    {icur_v, vin_v, vout_v, iref_v, kp_v, ki_v} = '0;

    // R4: exact unity ratio is not saturation
    run_step(0, 0, 0, 0, 0, 8000, 8000, 4095, "R4");
    // R2: proportional only
    run_step(900, 65536 * 2, 0, 0, 100, 10000, 4000, 1000, "R2");
    // R3: integral only, second step shows the accumulator
    run_step(600, 0, 20000 * 65536, 50000, 0, 10000, 3000, 1000, "R3");
    run_step(600, 0, 20000 * 65536, 50000, 0, 10000, 3000, 1000, "R3");
    // R8: saturating step must not integrate
    do_reset();
    run_step(2000, 0, 30000 * 65536, 100000, 0, 5000, 9000, 1000, "R5");
    run_step(0, 0, 0, 0, 0, 10000, 5000, 1000, "R8");
    // R6 and R7 directed
    run_step(0, 0, 0, 0, 0, 10000, 0, 1000, "R6");
    run_step(0, 65536, 0, 0, 0, 0, 5000, 1000, "R7");
    run_step(0, 65536, 0, 0, 0, -3, 5000, 1000, "R7");

    // Grid sweep with a running integrator
    begin
      int n = 0;
      for (int vi = 0; vi < 5; vi++)
        for (int vo = 0; vo < 4; vo++)
          for (int ep = 0; ep < 3; ep++)
            for (int pr = 0; pr < 3; pr++) begin
              int ir, ic, kp, ki;
              longint ts;
              ir = (ep == 0) ? 0 : (ep == 1) ? 800 : -2000;
              ic = (ep == 0) ? 0 : (ep == 1) ? -300 : 400;
              kp = (n % 3 == 0) ? 65536 : (n % 3 == 1) ? -32768 : 3 * 65536;
              ki = (n % 4 == 0) ? 30000 * 65536 : (n % 4 == 1) ? -500000000 : (n % 4 == 2) ? 0 : 7000 * 65536;
              ts = (n % 2 == 0) ? 50000 : 20000;
              run_step(ir, kp, ki, ts, ic, vin_of(vi), vout_of(vo), per_of(pr), "");
              n++;
            end
    end

    // R9: tick scaling across periods at a fixed mid duty
    do_reset();
    for (int pr = 0; pr < 3; pr++)
      run_step(0, 0, 0, 0, 0, 9000, 3000, per_of(pr), "R9");

    // R11: reset mid-run discards the accumulator
    run_step(1500, 0, 30000 * 65536, 50000, 0, 20000, 6000, 4095, "R3");
    do_reset();
    run_step(0, 0, 0, 0, 0, 20000, 6000, 4095, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule